// File: doc/BRIEF.md
# Stereo Audio Routing Matrix with Deferred Routing Default

The block is a full crossbar for digital stereo sample buses. Four external stereo source pairs and one stereo signal from the DSP can be routed to two stereo output pairs. The same matrix also drives a separate stereo selector whose output feeds the DSP input. A single 16-bit routing word holds one 3-bit select code for each destination. New samples are taken into the destination registers only on a sample strobe, so a selection never changes partway through a sample.

The routing word is written over a host bus that carries a subaddress, a register address and a data word. The block answers only to subaddress 0x12. A small bank of general configuration registers sits next to the routing word. The active-low general reset returns that bank to its defaults. It does not touch the routing word or the crossbar outputs, so a route that is set up before standby keeps passing audio while the rest of the chip is held off. After a reset the routing default is not loaded at once. It is held pending and is loaded on the first host write to subaddress 0x12. If that first write is to the routing word, the written value takes effect and the default is dropped.

Top module: `audio_matrix_switch`

## Requirements
- R1: While `rst_n` is low, `dflt_pending` reads 1 and every configuration register in `cfg_word` reads 0x0000.
- R2: A general reset leaves `route_word` unchanged. After the reset, strobed outputs still follow the routing that was set before it.
- R3: `dflt_pending` is cleared by the first accepted write to subaddress 0x12. Writes to any other subaddress change neither `dflt_pending`, `route_word` nor `cfg_word`.
- R4: When `dflt_pending` is 1 and the accepted write to subaddress 0x12 is not to the routing register, `route_word` becomes 0x0048 (output pair 0 takes the DSP source, output pair 1 takes input pair 1, the DSP selector takes input pair 1).
- R5: A write to subaddress 0x12, register 0x13, loads `host_data` into `route_word` whether or not a default is pending. Once the default has been dropped, later writes to other registers leave `route_word` unchanged.
- R6: Field layout of `route_word`: bits [2:0] select output pair 0, bits [5:3] select output pair 1 and bits [8:6] select the DSP input selector. On an output pair, code 0 selects the DSP source. On any destination, codes 1 to 4 select input pairs 1 to 4. Codes 5 to 7 give silence (0), and so does code 0 on the DSP selector.
- R7: Any input pair can reach any destination, and several destinations can take the same source. Left and right always come from the same pair.
- R8: Destination outputs load on a clock edge where `smp_vld` is 1, using the `route_word` held before that edge, and are seen one cycle later. Without a strobe they hold, even across a routing write.
- R9: While `stby_n` is low, host writes are ignored, but strobed outputs keep following the current routing.
- R10: Configuration registers 0 to 3 live at register addresses 0x00 to 0x03 of subaddress 0x12 and hold the written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low general reset |
| stby_n | input | 1 | Low while the chip is in standby |
| host_wr | input | 1 | Host write strobe |
| host_sub | input | 8 | Host write subaddress |
| host_reg | input | 8 | Register address within the subaddress |
| host_data | input | 16 | Host write data |
| smp_vld | input | 1 | Sample strobe; destinations load on it |
| src_l | input | 64 | Left samples of input pairs 1 to 4, pair 1 in bits [15:0] |
| src_r | input | 64 | Right samples of input pairs 1 to 4 |
| dsp_l | input | 16 | Left sample from the DSP |
| dsp_r | input | 16 | Right sample from the DSP |
| out_l | output | 32 | Left samples of output pairs 0 and 1, pair 0 in bits [15:0] |
| out_r | output | 32 | Right samples of output pairs 0 and 1 |
| dspin_l | output | 16 | Left sample towards the DSP input |
| dspin_r | output | 16 | Right sample towards the DSP input |
| route_word | output | 16 | Active routing word |
| dflt_pending | output | 1 | 1 while the routing default is still pending |
| cfg_word | output | 64 | Configuration registers 0 to 3, register 0 in bits [15:0] |

## Verification
The hardest state to reach from the ports is a reset that arrives after a routing has already been set. Its effect has to be told apart from a default load that happens to give the same value. The stimulus first moves the routing away from the default value, then passes through standby with ignored writes and new input data, and then applies the general reset. The first write after that reset goes to the routing register, so the dropped default and the retained route can each be seen on `route_word` and on the strobed outputs.

// File: rtl/mxs_pkg.sv
// Package: shared constants for the audio routing matrix.
// Assumes 3-bit select codes packed from bit 0 of a 16-bit routing word.
package mxs_pkg;
    localparam int SEL_W    = 3;
    localparam int ROUTE_W  = 16;
    localparam int REG_W    = 16;
    localparam int ADDR_W   = 8;

    typedef logic [SEL_W-1:0] sel_t;

    // Low bit of the select field for destination k.
    function automatic int field_lsb(input int k);
        return k * SEL_W;
    endfunction
endpackage

// File: rtl/mxs_ctrl_regs.sv
// Module: host-side control registers.
// Holds the routing word, which has no reset and loads its default lazily,
// a pending-default flag and a bank of general configuration registers.
// Assumes the routing register address differs from the configuration
// register addresses 0 .. NUM_CFG-1.
module mxs_ctrl_regs
    import mxs_pkg::*;
#(
    parameter int                 NUM_CFG       = 4,
    parameter logic [ADDR_W-1:0]  HOST_SUB      = 8'h12,
    parameter logic [ADDR_W-1:0]  ROUTE_REG     = 8'h13,
    parameter logic [ROUTE_W-1:0] ROUTE_DEFAULT = 16'h0048,
    parameter logic [REG_W-1:0]   CFG_RESET     = 16'h0000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stby_n,
    input  logic                     host_wr,
    input  logic [ADDR_W-1:0]        host_sub,
    input  logic [ADDR_W-1:0]        host_reg,
    input  logic [REG_W-1:0]         host_data,
    output logic [ROUTE_W-1:0]       route_word,
    output logic                     dflt_pending,
    output logic [NUM_CFG*REG_W-1:0] cfg_flat
);
    localparam int CFG_BITS = NUM_CFG * REG_W;

    logic wr_hit;
    logic route_hit;
    logic [ROUTE_W-1:0] route_q;
    logic pending_q;

    // Decode an accepted write to this block's subaddress.
    always_comb begin
        wr_hit    = host_wr && stby_n && (host_sub == HOST_SUB);
        route_hit = wr_hit && (host_reg == ROUTE_REG);
    end

    // Pending flag: armed by reset, dropped by the first accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending_q <= 1'b1;
        else if (wr_hit)
            pending_q <= 1'b0;
    end

    // Routing word: survives reset; explicit write wins over the pending default.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            if (route_hit)
                route_q <= host_data;
            else if (wr_hit && pending_q)
                route_q <= ROUTE_DEFAULT;
        end
    end

    // One general configuration register per address, cleared by reset.
    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
        logic [REG_W-1:0] cfg_q;

        // Configuration register g: reset value or host write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_q <= CFG_RESET;
            else if (wr_hit && (host_reg == ADDR_W'(g)))
                cfg_q <= host_data;
        end

        assign cfg_flat[g*REG_W +: REG_W] = cfg_q;
    end

    assign route_word   = route_q;
    assign dflt_pending = pending_q;

    if (CFG_BITS < REG_W) begin : g_bad_cfg
        $error("mxs_ctrl_regs: NUM_CFG must be at least 1");
    end
endmodule

// File: rtl/mxs_stereo_sel.sv
// Module: one stereo destination of the crossbar.
// Picks a source pair by select code and captures it on the sample strobe.
// Code 0 is the DSP source when ALLOW_DSP is set, codes 1..NUM_IN pick the
// input pairs and every other code gives silence. No reset: the captured
// sample must survive a general reset.
module mxs_stereo_sel
    import mxs_pkg::*;
#(
    parameter int SMP_W     = 16,
    parameter int NUM_IN    = 4,
    parameter bit ALLOW_DSP = 1'b1
) (
    input  logic                    clk,
    input  logic                    smp_vld,
    input  sel_t                    sel,
    input  logic [NUM_IN*SMP_W-1:0] src_l,
    input  logic [NUM_IN*SMP_W-1:0] src_r,
    input  logic [SMP_W-1:0]        dsp_l,
    input  logic [SMP_W-1:0]        dsp_r,
    output logic [SMP_W-1:0]        out_l,
    output logic [SMP_W-1:0]        out_r
);
    logic [SMP_W-1:0] pick_l;
    logic [SMP_W-1:0] pick_r;

    // Source selection for the current code, silence by default.
    always_comb begin
        pick_l = '0;
        pick_r = '0;
        if (ALLOW_DSP && (sel == '0)) begin
            pick_l = dsp_l;
            pick_r = dsp_r;
        end
        for (int i = 0; i < NUM_IN; i++) begin
            if (int'(sel) == i + 1) begin
                pick_l = src_l[i*SMP_W +: SMP_W];
                pick_r = src_r[i*SMP_W +: SMP_W];
            end
        end
    end

    // Capture the picked pair only at a sample boundary.
    always_ff @(posedge clk) begin
        if (smp_vld) begin
            out_l <= pick_l;
            out_r <= pick_r;
        end
    end
endmodule

// File: rtl/audio_matrix_switch.sv
// Module: top of the stereo routing matrix.
// Connects the control registers to NUM_OUT output selectors and one DSP
// input selector. Assumes the select fields fit into the 16-bit routing word.
module audio_matrix_switch
    import mxs_pkg::*;
#(
    parameter int                 SMP_W         = 16,
    parameter int                 NUM_IN        = 4,
    parameter int                 NUM_OUT       = 2,
    parameter int                 NUM_CFG       = 4,
    parameter logic [7:0]         HOST_SUB      = 8'h12,
    parameter logic [7:0]         ROUTE_REG     = 8'h13,
    parameter logic [15:0]        ROUTE_DEFAULT = 16'h0048
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stby_n,
    input  logic                     host_wr,
    input  logic [7:0]               host_sub,
    input  logic [7:0]               host_reg,
    input  logic [15:0]              host_data,
    input  logic                     smp_vld,
    input  logic [NUM_IN*SMP_W-1:0]  src_l,
    input  logic [NUM_IN*SMP_W-1:0]  src_r,
    input  logic [SMP_W-1:0]         dsp_l,
    input  logic [SMP_W-1:0]         dsp_r,
    output logic [NUM_OUT*SMP_W-1:0] out_l,
    output logic [NUM_OUT*SMP_W-1:0] out_r,
    output logic [SMP_W-1:0]         dspin_l,
    output logic [SMP_W-1:0]         dspin_r,
    output logic [15:0]              route_word,
    output logic                     dflt_pending,
    output logic [NUM_CFG*16-1:0]    cfg_word
);
    localparam int DSP_LSB   = field_lsb(NUM_OUT);
    localparam int USED_BITS = DSP_LSB + SEL_W;

    if (USED_BITS > ROUTE_W) begin : g_bad_fields
        $error("audio_matrix_switch: select fields exceed routing word");
    end
    if (NUM_IN + 1 > (1 << SEL_W)) begin : g_bad_inputs
        $error("audio_matrix_switch: too many inputs for the select code");
    end

    mxs_ctrl_regs #(
        .NUM_CFG       (NUM_CFG),
        .HOST_SUB      (HOST_SUB),
        .ROUTE_REG     (ROUTE_REG),
        .ROUTE_DEFAULT (ROUTE_DEFAULT),
        .CFG_RESET     (16'h0000)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .stby_n       (stby_n),
        .host_wr      (host_wr),
        .host_sub     (host_sub),
        .host_reg     (host_reg),
        .host_data    (host_data),
        .route_word   (route_word),
        .dflt_pending (dflt_pending),
        .cfg_flat     (cfg_word)
    );

    // Output pair selectors, one select field each.
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        mxs_stereo_sel #(
            .SMP_W     (SMP_W),
            .NUM_IN    (NUM_IN),
            .ALLOW_DSP (1'b1)
        ) u_sel (
            .clk     (clk),
            .smp_vld (smp_vld),
            .sel     (route_word[field_lsb(k) +: SEL_W]),
            .src_l   (src_l),
            .src_r   (src_r),
            .dsp_l   (dsp_l),
            .dsp_r   (dsp_r),
            .out_l   (out_l[k*SMP_W +: SMP_W]),
            .out_r   (out_r[k*SMP_W +: SMP_W])
        );
    end

    // DSP input selector: external pairs only, never the DSP itself.
    mxs_stereo_sel #(
        .SMP_W     (SMP_W),
        .NUM_IN    (NUM_IN),
        .ALLOW_DSP (1'b0)
    ) u_dsp_sel (
        .clk     (clk),
        .smp_vld (smp_vld),
        .sel     (route_word[DSP_LSB +: SEL_W]),
        .src_l   (src_l),
        .src_r   (src_r),
        .dsp_l   (dsp_l),
        .dsp_r   (dsp_r),
        .out_l   (dspin_l),
        .out_r   (dspin_r)
    );
endmodule

// File: rtl/mxs_checker.sv
// Module: property checker for audio_matrix_switch, attached by bind.
// Tracks when the routing word and the outputs first hold known values so
// that no property looks at the unset power-on state.
module mxs_checker #(
    parameter int         SMP_W         = 16,
    parameter int         NUM_IN        = 4,
    parameter int         NUM_OUT       = 2,
    parameter logic [7:0] HOST_SUB      = 8'h12,
    parameter logic [7:0] ROUTE_REG     = 8'h13,
    parameter logic [15:0] ROUTE_DEFAULT = 16'h0048
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     stby_n,
    input logic                     host_wr,
    input logic [7:0]               host_sub,
    input logic [7:0]               host_reg,
    input logic [15:0]              host_data,
    input logic                     smp_vld,
    input logic [NUM_OUT*SMP_W-1:0] out_l,
    input logic [NUM_OUT*SMP_W-1:0] out_r,
    input logic [15:0]              route_word,
    input logic                     dflt_pending
);
    logic hit;
    logic route_known = 1'b0;
    logic out_known   = 1'b0;

    // Accepted write to this block's subaddress.
    assign hit = host_wr && stby_n && (host_sub == HOST_SUB);

    // Mark the routing word as known after its first load.
    always_ff @(posedge clk) begin
        if (rst_n && hit)
            route_known <= 1'b1;
    end

    // Mark the outputs as known after the first strobe on a known route.
    always_ff @(posedge clk) begin
        if (smp_vld && route_known)
            out_known <= 1'b1;
    end

    assert_keep_route_R2: assert property (@(posedge clk)
        (route_known && !rst_n) |=> (route_word == $past(route_word)));

    assert_pending_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !dflt_pending);

    assert_pending_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dflt_pending && !hit) |=> dflt_pending);

    assert_default_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && dflt_pending && (host_reg != ROUTE_REG)) |=> (route_word == ROUTE_DEFAULT));

    assert_route_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (host_reg == ROUTE_REG)) |=> (route_word == $past(host_data)));

    assert_silence_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (route_known && smp_vld && (int'(route_word[2:0]) > NUM_IN))
        |=> ((out_l[SMP_W-1:0] == '0) && (out_r[SMP_W-1:0] == '0)));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_known && !smp_vld) |=> ($stable(out_l) && $stable(out_r)));

    assert_standby_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (route_known && !stby_n) |=> $stable(route_word));
endmodule

bind audio_matrix_switch mxs_checker #(
    .SMP_W         (SMP_W),
    .NUM_IN        (NUM_IN),
    .NUM_OUT       (NUM_OUT),
    .HOST_SUB      (HOST_SUB),
    .ROUTE_REG     (ROUTE_REG),
    .ROUTE_DEFAULT (ROUTE_DEFAULT)
) u_mxs_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .stby_n       (stby_n),
    .host_wr      (host_wr),
    .host_sub     (host_sub),
    .host_reg     (host_reg),
    .host_data    (host_data),
    .smp_vld      (smp_vld),
    .out_l        (out_l),
    .out_r        (out_r),
    .route_word   (route_word),
    .dflt_pending (dflt_pending)
);

// File: tb/tb_audio_matrix_switch.sv
`timescale 1ns/1ps
// Bench: walks a routing vector table, then directed tests for reset,
// deferred default, standby and strobe timing.
module tb_audio_matrix_switch;
    localparam int W  = 16;
    localparam int NI = 4;
    localparam int NO = 2;
    localparam int NC = 4;
    localparam logic [7:0] SUB = 8'h12;
    localparam logic [7:0] RREG = 8'h13;
    localparam logic [15:0] DEF = 16'h0048;

    // Routing vectors: {out0 code, out1 code, dsp code}.
    localparam logic [2:0] VEC [8][3] = '{
        '{3'd1, 3'd2, 3'd3}, '{3'd4, 3'd3, 3'd2}, '{3'd2, 3'd4, 3'd4},
        '{3'd0, 3'd1, 3'd0}, '{3'd3, 3'd0, 3'd1}, '{3'd5, 3'd6, 3'd7},
        '{3'd7, 3'd4, 3'd1}, '{3'd1, 3'd1, 3'd5}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stby_n = 1'b1;
    logic host_wr = 1'b0;
    logic [7:0] host_sub = '0;
    logic [7:0] host_reg = '0;
    logic [15:0] host_data = '0;
    logic smp_vld = 1'b0;
    logic [NI*W-1:0] src_l, src_r;
    logic [W-1:0] dsp_l, dsp_r;
    logic [NO*W-1:0] out_l, out_r;
    logic [W-1:0] dspin_l, dspin_r;
    logic [15:0] route_word;
    logic dflt_pending;
    logic [NC*16-1:0] cfg_word;

    int n_chk = 0;
    int n_err = 0;
    logic [15:0] base = 16'h0000;

    always #2 clk = ~clk;

    audio_matrix_switch dut (
        .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .host_wr(host_wr),
        .host_sub(host_sub), .host_reg(host_reg), .host_data(host_data),
        .smp_vld(smp_vld), .src_l(src_l), .src_r(src_r), .dsp_l(dsp_l),
        .dsp_r(dsp_r), .out_l(out_l), .out_r(out_r), .dspin_l(dspin_l),
        .dspin_r(dspin_r), .route_word(route_word), .dflt_pending(dflt_pending),
        .cfg_word(cfg_word));

    // Drive distinct source samples offset by base.
    task automatic set_sources();
        for (int i = 0; i < NI; i++) begin
            src_l[i*W +: W] = base + 16'h1100 + 16'(i) * 16'h0111;
            src_r[i*W +: W] = base + 16'h2100 + 16'(i) * 16'h0111;
        end
        dsp_l = base + 16'h3A3A;
        dsp_r = base + 16'h3B3B;
    endtask

    // Expected sample for a code, per the R6 encoding.
    function automatic logic [W-1:0] exp_smp(input logic [2:0] code, input bit allow_dsp,
                                             input bit right);
        if (code == 3'd0) return allow_dsp ? (right ? dsp_r : dsp_l) : '0;
        if (int'(code) <= NI) return right ? src_r[(int'(code)-1)*W +: W]
                                            : src_l[(int'(code)-1)*W +: W];
        return '0;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Compare all destinations against the routing word rt.
    task automatic check_outs(input string req, input logic [15:0] rt);
        for (int k = 0; k < NO; k++) begin
            check(req, 64'(out_l[k*W +: W]), 64'(exp_smp(rt[3*k +: 3], 1'b1, 1'b0)));
            check(req, 64'(out_r[k*W +: W]), 64'(exp_smp(rt[3*k +: 3], 1'b1, 1'b1)));
        end
        check(req, 64'(dspin_l), 64'(exp_smp(rt[8:6], 1'b0, 1'b0)));
        check(req, 64'(dspin_r), 64'(exp_smp(rt[8:6], 1'b0, 1'b1)));
    endtask

    task automatic host_write(input logic [7:0] s, input logic [7:0] r, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sub = s; host_reg = r; host_data = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk);
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #400000;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [15:0] rt;
        logic [15:0] prev;
        set_sources();
        repeat (3) @(negedge clk);
        check("R1 pending", 64'(dflt_pending), 64'd1);
        check("R1 cfg", 64'(cfg_word), 64'd0);
        rst_n = 1'b1;

        // R3: foreign subaddress has no effect.
        host_write(8'h10, 8'h01, 16'h7777);
        check("R3 pending kept", 64'(dflt_pending), 64'd1);
        check("R3 cfg untouched", 64'(cfg_word), 64'd0);

        // R4 / R10: first write to a config register loads the default.
        host_write(SUB, 8'h01, 16'hABCD);
        check("R3 pending cleared", 64'(dflt_pending), 64'd0);
        check("R4 default route", 64'(route_word), 64'(DEF));
        check("R10 cfg1", 64'(cfg_word[31:16]), 64'hABCD);
        strobe();
        check_outs("R6 default routing", DEF);

        // R6 / R7: vector table walk.
        for (int v = 0; v < 8; v++) begin
            rt = {7'd0, VEC[v][2], VEC[v][1], VEC[v][0]};
            host_write(SUB, RREG, rt);
            check("R5 route write", 64'(route_word), 64'(rt));
            strobe();
            check_outs("R7 matrix vector", rt);
        end

        // R5: after default dropped, config writes leave route alone.
        host_write(SUB, 8'h00, 16'h1234);
        check("R5 route kept", 64'(route_word), 64'(rt));
        check("R10 cfg0", 64'(cfg_word[15:0]), 64'h1234);

        // R8: routing write without strobe holds outputs.
        prev = rt;
        rt = 16'h00A3;
        host_write(SUB, RREG, rt);
        check_outs("R8 hold without strobe", prev);
        // R8: strobe in the same cycle as a write uses the old route.
        prev = rt;
        @(negedge clk);
        host_wr = 1'b1; host_sub = SUB; host_reg = RREG; host_data = 16'h0091;
        smp_vld = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; smp_vld = 1'b0;
        check_outs("R8 strobe uses old route", prev);
        check("R8 new route loaded", 64'(route_word), 64'h0091);
        rt = 16'h0091;

        // R9: standby ignores writes, keeps passing samples.
        stby_n = 1'b0;
        host_write(SUB, RREG, 16'h01FF);
        host_write(SUB, 8'h02, 16'h4444);
        check("R9 route frozen", 64'(route_word), 64'(rt));
        check("R9 cfg frozen", 64'(cfg_word[47:32]), 64'h0000);
        base = 16'h0404;
        set_sources();
        strobe();
        check_outs("R9 passes in standby", rt);

        // R2 / R1: general reset keeps route, clears config.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 pending on reset", 64'(dflt_pending), 64'd1);
        check("R1 cfg cleared", 64'(cfg_word), 64'd0);
        check("R2 route survives reset", 64'(route_word), 64'(rt));
        rst_n = 1'b1;
        stby_n = 1'b1;
        base = 16'h0808;
        set_sources();
        strobe();
        check_outs("R2 routing after reset", rt);

        // R5: first write is the route itself; default never applied.
        host_write(SUB, RREG, 16'h0062);
        check("R5 first write route", 64'(route_word), 64'h0062);
        check("R5 pending cleared", 64'(dflt_pending), 64'd0);
        host_write(SUB, 8'h02, 16'h5555);
        check("R5 no late default", 64'(route_word), 64'h0062);
        check("R10 cfg2", 64'(cfg_word[47:32]), 64'h5555);
        strobe();
        check_outs("R6 after redefinition", 16'h0062);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule